// File: doc/BRIEF.md
# Speed-Mode PHY Configuration Sequencer

This block keeps the pad and timing settings of a card-interface PHY in step with the interface's operating point. The host side presents the current card clock rate in kHz, the bus width and a speed-mode code. It also presents two configuration levels: one says whether the card is an SDIO card, the other is a board strap that requests the slow bypass path. The block remembers the operating point it last applied. When the clock, width or speed mode moves away from that copy, it captures the inputs and writes a fixed, ordered series of register updates, one step per cycle:

1. It enables the pad receivers.
2. It sets the SDIO and slow bits in the timing-adjust register.
3. It loads the drive-strength codes.
4. It gates the card clock, writes the function-control word and ungates the clock.
5. It writes either the HS400 logic-timing constant or clears the data-strobe enable.

A one-cycle init-start pulse closes the series. The block then waits for the PHY to report that initialization is done.

Legacy mode, and any mode that ends up on the slow bypass path, skips the high-speed steps and goes straight to the init pulse. The register contents are outputs, so the PHY and any status logic observe them directly.

Top module: `phy_mode_seq`

## Requirements
- R1: While the block is idle and `clk_khz` is 0, no sequence starts and the remembered clock is cleared. A later nonzero clock therefore starts a sequence even if it equals the clock applied before.
- R2: A sequence starts only when the clock, the bus width or the speed mode differs from the values applied by the last sequence. A change of `card_sdio` or `slow_strap` alone starts nothing.
- R3: Every sequence ORs the receiver-enable mask 0x1700F000 into `pad_cfg`, which resets to 0.
- R4: Mode codes are: 0 legacy, 1 SD high speed, 2 MMC high speed, 3 SDR12, 4 SDR25, 5 SDR50, 6 SDR104, 7 DDR50, 8 DDR52, 9 HS200, 10 HS400. Bit 29 of `timing_adj` (slow) is cleared above 52000 kHz. At or below 52000 kHz it is set as follows:
  - in legacy mode, it equals `slow_strap`;
  - in modes 1 to 4, it is set when `card_sdio` or `slow_strap` is high;
  - in every other mode, it is cleared.
- R5: In non-legacy modes, bit 28 of `timing_adj` takes `card_sdio`. A legacy sequence leaves bit 28 unchanged.
- R6: When the mode is legacy or slow is set, the sequence leaves `pad_drv`, `func_ctrl`, `logic_timing` and `strobe_en` unchanged and never drops `card_clk_en`.
- R7: `card_clk_en` is low during the cycle in which `func_ctrl` is written. It is high at all other times outside the gate window, and after reset.
- R8: `func_ctrl` takes the following value, where bits [15:8] are the data DDR lanes, bit 16 is command DDR and bit 4 is async:
  - HS400: 0x0001FF00;
  - DDR50 or DDR52: 0x0001FF10;
  - any other fast-path mode: 0x00000010.
- R9: On the fast path, `pad_drv` bits [12:8] take the N-side code and bits [4:0] the P-side code. Both codes default to 0xF, which gives 0x00000F0F.
- R10: On the fast path, HS400 loads `logic_timing` with 0x00AA8977 and leaves `strobe_en` alone. Any other mode clears `strobe_en`, which resets to 1.
- R11: Each sequence ends with `init_start` high for exactly one cycle. `busy` stays high until `init_done` is seen, and no new change is taken up before then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_khz | input | CLKW | Current card clock rate in kHz, 0 when stopped |
| bus_width | input | BWW | Current bus width code |
| speed_mode | input | 4 | Speed-mode code (R4) |
| card_sdio | input | 1 | Card is an SDIO card |
| slow_strap | input | 1 | Board request for slow bypass mode |
| init_done | input | 1 | PHY initialization finished |
| timing_adj | output | 32 | Timing-adjust register: bit 29 slow, bit 28 SDIO |
| pad_cfg | output | 32 | Pad receiver control register |
| pad_drv | output | 32 | Drive-strength register: N code [12:8], P code [4:0] |
| func_ctrl | output | 32 | Function-control register (DDR lanes, command DDR, async) |
| logic_timing | output | 32 | Logic timing-adjust register |
| strobe_en | output | 1 | Data-strobe enable |
| card_clk_en | output | 1 | Card clock enable |
| init_start | output | 1 | One-cycle PHY initialization request |
| busy | output | 1 | Sequence in progress or waiting for init_done |

## Verification
Suppose the remembered operating point is wrong. The block would then either miss a sequence, so no `init_start` appears within about ten cycles of an input change, or start one when nothing changed. Either case is visible at the pulse output right away.

Suppose instead the slow/legacy branch is decided wrongly. Then at the end of the sequence the drive, function or strobe registers hold values that are stale or were written when they should not have been. In addition, the card clock drop either appears where it should not, or is missing.

Because registers are overwritten one step at a time, a wrong step order or a wrong decode shows up in the final register values. Those values can be read a cycle after `init_done`.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  typedef enum logic [3:0] {
    SPD_LEGACY = 4'd0,
    SPD_SD_HS  = 4'd1,
    SPD_MMC_HS = 4'd2,
    SPD_SDR12  = 4'd3,
    SPD_SDR25  = 4'd4,
    SPD_SDR50  = 4'd5,
    SPD_SDR104 = 4'd6,
    SPD_DDR50  = 4'd7,
    SPD_DDR52  = 4'd8,
    SPD_HS200  = 4'd9,
    SPD_HS400  = 4'd10
  } spd_mode_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PAD, ST_SDIO, ST_SLOW, ST_DRIVE, ST_GATE,
    ST_FUNC, ST_UNGATE, ST_FINAL, ST_INIT, ST_WAIT
  } seq_st_e;

  localparam int TA_SLOW_BIT = 29;
  localparam int TA_SDIO_BIT = 28;
  localparam logic [31:0] PAD_RX_MASK   = 32'h1700_F000;
  localparam logic [31:0] HS400_LOGIC_T = 32'h00AA_8977;

  // slow bypass decision; low_clk means rate at or under the slow limit
  function automatic logic want_slow(input logic [3:0] mode, input logic sdio,
                                     input logic strap, input logic low_clk);
    logic r;
    r = 1'b0;
    if (low_clk) begin
      case (mode)
        SPD_LEGACY: r = strap;
        SPD_SD_HS, SPD_MMC_HS, SPD_SDR12, SPD_SDR25: r = sdio | strap;
        default: r = 1'b0;
      endcase
    end
    return r;
  endfunction

  // function-control word: [15:8] data DDR lanes, [16] cmd DDR, [4] async
  function automatic logic [31:0] func_word(input logic [3:0] mode);
    logic ddr, async_m;
    logic [31:0] w;
    ddr     = (mode == SPD_HS400) || (mode == SPD_DDR50) || (mode == SPD_DDR52);
    async_m = (mode != SPD_HS400);
    w = '0;
    w[15:8] = {8{ddr}};
    w[16]   = ddr;
    w[4]    = async_m;
    return w;
  endfunction

endpackage

// File: rtl/phy_opt_track.sv
module phy_opt_track #(
  parameter int CLKW = 20,
  parameter int BWW  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CLKW-1:0] cur_clk,
  input  logic [BWW-1:0]  cur_width,
  input  logic [3:0]      cur_mode,
  input  logic            commit,
  input  logic [CLKW-1:0] new_clk,
  input  logic [BWW-1:0]  new_width,
  input  logic [3:0]      new_mode,
  input  logic            clr_clk,
  output logic            differs
);
  logic [CLKW-1:0] st_clk;
  logic [BWW-1:0]  st_width;
  logic [3:0]      st_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_clk   <= '0;
      st_width <= '0;
      st_mode  <= 4'd0;
    end else if (commit) begin
      st_clk   <= new_clk;
      st_width <= new_width;
      st_mode  <= new_mode;
    end else if (clr_clk) begin
      st_clk   <= '0;
    end
  end

  assign differs = (cur_clk != st_clk) || (cur_width != st_width) ||
                   (cur_mode != st_mode);
endmodule

// File: rtl/phy_seq_ctrl.sv
module phy_seq_ctrl
  import phy_seq_pkg::*;
#(
  parameter int CLKW = 20,
  parameter int BWW  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [CLKW-1:0] in_clk,
  input  logic [BWW-1:0]  in_width,
  input  logic [3:0]      in_mode,
  input  logic            in_sdio,
  input  logic            in_strap,
  input  logic            slow_req,
  input  logic            init_done,
  output seq_st_e         state,
  output logic [CLKW-1:0] snap_clk,
  output logic [BWW-1:0]  snap_width,
  output logic [3:0]      snap_mode,
  output logic            snap_sdio,
  output logic            snap_strap
);
  seq_st_e nxt;
  logic    legacy;

  assign legacy = (snap_mode == SPD_LEGACY);

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:   if (start) nxt = ST_PAD;
      ST_PAD:    nxt = legacy ? ST_SLOW : ST_SDIO;
      ST_SDIO:   nxt = ST_SLOW;
      ST_SLOW:   nxt = (legacy || slow_req) ? ST_INIT : ST_DRIVE;
      ST_DRIVE:  nxt = ST_GATE;
      ST_GATE:   nxt = ST_FUNC;
      ST_FUNC:   nxt = ST_UNGATE;
      ST_UNGATE: nxt = ST_FINAL;
      ST_FINAL:  nxt = ST_INIT;
      ST_INIT:   nxt = ST_WAIT;
      ST_WAIT:   if (init_done) nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      snap_clk   <= '0;
      snap_width <= '0;
      snap_mode  <= 4'd0;
      snap_sdio  <= 1'b0;
      snap_strap <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_IDLE && start) begin
        snap_clk   <= in_clk;
        snap_width <= in_width;
        snap_mode  <= in_mode;
        snap_sdio  <= in_sdio;
        snap_strap <= in_strap;
      end
    end
  end
endmodule

// File: rtl/phy_reg_bank.sv
module phy_reg_bank
  import phy_seq_pkg::*;
#(
  parameter logic [4:0] DRV_N = 5'hF,
  parameter logic [4:0] DRV_P = 5'hF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  seq_st_e     state,
  input  logic [3:0]  snap_mode,
  input  logic        snap_sdio,
  input  logic        slow_req,
  output logic [31:0] timing_adj,
  output logic [31:0] pad_cfg,
  output logic [31:0] pad_drv,
  output logic [31:0] func_ctrl,
  output logic [31:0] logic_timing,
  output logic        strobe_en,
  output logic        card_clk_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timing_adj   <= '0;
      pad_cfg      <= '0;
      pad_drv      <= '0;
      func_ctrl    <= '0;
      logic_timing <= '0;
      strobe_en    <= 1'b1;
      card_clk_en  <= 1'b1;
    end else begin
      case (state)
        ST_PAD:    pad_cfg <= pad_cfg | PAD_RX_MASK;
        ST_SDIO:   timing_adj[TA_SDIO_BIT] <= snap_sdio;
        ST_SLOW:   timing_adj[TA_SLOW_BIT] <= slow_req;
        ST_DRIVE: begin
          pad_drv[12:8] <= DRV_N;
          pad_drv[4:0]  <= DRV_P;
        end
        ST_GATE:   card_clk_en <= 1'b0;
        ST_FUNC:   func_ctrl <= func_word(snap_mode);
        ST_UNGATE: card_clk_en <= 1'b1;
        ST_FINAL: begin
          if (snap_mode == SPD_HS400) logic_timing <= HS400_LOGIC_T;
          else                        strobe_en    <= 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/phy_mode_seq.sv
module phy_mode_seq
  import phy_seq_pkg::*;
#(
  parameter int         CLKW           = 20,
  parameter int         BWW            = 2,
  parameter int         SLOW_LIMIT_KHZ = 52000,
  parameter logic [4:0] DRV_N          = 5'hF,
  parameter logic [4:0] DRV_P          = 5'hF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CLKW-1:0] clk_khz,
  input  logic [BWW-1:0]  bus_width,
  input  logic [3:0]      speed_mode,
  input  logic            card_sdio,
  input  logic            slow_strap,
  input  logic            init_done,
  output logic [31:0]     timing_adj,
  output logic [31:0]     pad_cfg,
  output logic [31:0]     pad_drv,
  output logic [31:0]     func_ctrl,
  output logic [31:0]     logic_timing,
  output logic            strobe_en,
  output logic            card_clk_en,
  output logic            init_start,
  output logic            busy
);
  localparam logic [CLKW-1:0] LIMIT = CLKW'(SLOW_LIMIT_KHZ);

  seq_st_e         state;
  logic [CLKW-1:0] snap_clk;
  logic [BWW-1:0]  snap_width;
  logic [3:0]      snap_mode;
  logic            snap_sdio, snap_strap;
  logic            differs, clk_nz, is_idle;
  logic            seq_start, zero_clr, slow_req;
  logic            func_wr, seq_waiting;

  assign clk_nz      = |clk_khz;
  assign is_idle     = (state == ST_IDLE);
  assign seq_start   = is_idle && clk_nz && differs;
  assign zero_clr    = is_idle && !clk_nz;
  assign slow_req    = want_slow(snap_mode, snap_sdio, snap_strap, snap_clk <= LIMIT);
  assign func_wr     = (state == ST_FUNC);
  assign seq_waiting = (state == ST_WAIT);
  assign init_start  = (state == ST_INIT);
  assign busy        = !is_idle;

  phy_opt_track #(.CLKW(CLKW), .BWW(BWW)) u_track (
    .clk(clk), .rst_n(rst_n),
    .cur_clk(clk_khz), .cur_width(bus_width), .cur_mode(speed_mode),
    .commit(init_start), .new_clk(snap_clk), .new_width(snap_width),
    .new_mode(snap_mode), .clr_clk(zero_clr), .differs(differs)
  );

  phy_seq_ctrl #(.CLKW(CLKW), .BWW(BWW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(seq_start),
    .in_clk(clk_khz), .in_width(bus_width), .in_mode(speed_mode),
    .in_sdio(card_sdio), .in_strap(slow_strap), .slow_req(slow_req),
    .init_done(init_done), .state(state),
    .snap_clk(snap_clk), .snap_width(snap_width), .snap_mode(snap_mode),
    .snap_sdio(snap_sdio), .snap_strap(snap_strap)
  );

  phy_reg_bank #(.DRV_N(DRV_N), .DRV_P(DRV_P)) u_bank (
    .clk(clk), .rst_n(rst_n), .state(state), .snap_mode(snap_mode),
    .snap_sdio(snap_sdio), .slow_req(slow_req),
    .timing_adj(timing_adj), .pad_cfg(pad_cfg), .pad_drv(pad_drv),
    .func_ctrl(func_ctrl), .logic_timing(logic_timing),
    .strobe_en(strobe_en), .card_clk_en(card_clk_en)
  );
endmodule

// File: rtl/phy_seq_chk.sv
module phy_seq_chk #(
  parameter int CLKW           = 20,
  parameter int SLOW_LIMIT_KHZ = 52000
) (
  input logic            clk,
  input logic            rst_n,
  input logic [CLKW-1:0] clk_khz,
  input logic [CLKW-1:0] snap_clk,
  input logic            seq_start,
  input logic            func_wr,
  input logic            seq_waiting,
  input logic            init_start,
  input logic            init_done,
  input logic            busy,
  input logic            card_clk_en,
  input logic            slow_bit
);
  localparam logic [CLKW-1:0] LIMIT = CLKW'(SLOW_LIMIT_KHZ);

  a_r1_zero_clk_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_khz == '0 && !busy) |=> !busy);

  a_r2_start_enters_busy: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> busy);

  a_r4_slow_needs_low_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (init_start && slow_bit) |-> (snap_clk <= LIMIT));

  a_r6_no_func_when_slow: assert property (@(posedge clk) disable iff (!rst_n)
    func_wr |-> !slow_bit);

  a_r7_clock_gated_on_func: assert property (@(posedge clk) disable iff (!rst_n)
    func_wr |-> !card_clk_en);

  a_r11_init_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    init_start |=> !init_start);

  a_r11_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_waiting && !init_done) |=> busy);
endmodule

bind phy_mode_seq phy_seq_chk #(.CLKW(CLKW), .SLOW_LIMIT_KHZ(SLOW_LIMIT_KHZ)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_khz(clk_khz), .snap_clk(snap_clk),
  .seq_start(seq_start), .func_wr(func_wr), .seq_waiting(seq_waiting),
  .init_start(init_start), .init_done(init_done), .busy(busy),
  .card_clk_en(card_clk_en), .slow_bit(timing_adj[29])
);

// File: tb/sim_phy_mode_seq.sv
module sim_phy_mode_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] clk_khz = '0;
  logic [1:0]  bus_width = '0;
  logic [3:0]  speed_mode = '0;
  logic        card_sdio = 1'b0, slow_strap = 1'b0, init_done = 1'b0;
  logic [31:0] timing_adj, pad_cfg, pad_drv, func_ctrl, logic_timing;
  logic        strobe_en, card_clk_en, init_start, busy;

  int checks = 0, errors = 0;
  logic done_flag = 1'b0;

  // bench model of applied state and registers
  logic [19:0] m_clk = '0;
  logic [1:0]  m_w = '0;
  logic [3:0]  m_mode = '0;
  logic [31:0] e_ta = '0, e_pad = '0, e_drv = '0, e_func = '0, e_logic = '0;
  logic        e_strobe = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_mode_seq u0 (
    .clk(clk), .rst_n(rst_n), .clk_khz(clk_khz), .bus_width(bus_width),
    .speed_mode(speed_mode), .card_sdio(card_sdio), .slow_strap(slow_strap),
    .init_done(init_done), .timing_adj(timing_adj), .pad_cfg(pad_cfg),
    .pad_drv(pad_drv), .func_ctrl(func_ctrl), .logic_timing(logic_timing),
    .strobe_en(strobe_en), .card_clk_en(card_clk_en),
    .init_start(init_start), .busy(busy)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic b_slow(input logic [19:0] c, input logic [3:0] m,
                                  input logic s, input logic k);
    if (c > 20'd52000) return 1'b0;
    if (m == 4'd0) return k;
    if (m inside {4'd1, 4'd2, 4'd3, 4'd4}) return s || k;
    return 1'b0;
  endfunction

  function automatic logic [31:0] b_func(input logic [3:0] m);
    if (m == 4'd10) return 32'h0001_FF00;
    if (m == 4'd7 || m == 4'd8) return 32'h0001_FF10;
    return 32'h0000_0010;
  endfunction

  task automatic check_regs(input string why);
    chk(timing_adj == e_ta, {"R4/R5 timing_adj ", why}, timing_adj, e_ta);
    chk(pad_cfg == e_pad, {"R3 pad_cfg ", why}, pad_cfg, e_pad);
    chk(pad_drv == e_drv, {"R9 pad_drv ", why}, pad_drv, e_drv);
    chk(func_ctrl == e_func, {"R8 func_ctrl ", why}, func_ctrl, e_func);
    chk(logic_timing == e_logic, {"R10 logic_timing ", why}, logic_timing, e_logic);
    chk(strobe_en == e_strobe, {"R10 strobe_en ", why}, {31'b0, strobe_en}, {31'b0, e_strobe});
    chk(card_clk_en == 1'b1, {"R7 card_clk_en idle ", why}, {31'b0, card_clk_en}, 32'd1);
  endtask

  task automatic apply(input logic [19:0] c, input logic [1:0] w, input logic [3:0] m,
                       input logic s, input logic k, input string why);
    logic change, seen, gated, slow, fast;
    @(negedge clk);
    clk_khz = c; bus_width = w; speed_mode = m; card_sdio = s; slow_strap = k;
    change = (c != 0) && (c != m_clk || w != m_w || m != m_mode);
    if (c == 0) m_clk = '0;
    seen = 1'b0; gated = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!card_clk_en) gated = 1'b1;
      if (init_start) begin seen = 1'b1; break; end
    end
    chk(seen == change, {"R2/R1 sequence start ", why}, {31'b0, seen}, {31'b0, change});
    if (change && seen) begin
      slow = b_slow(c, m, s, k);
      fast = (m != 4'd0) && !slow;
      e_pad = e_pad | 32'h1700_F000;
      if (m != 4'd0) e_ta[28] = s;
      e_ta[29] = slow;
      if (fast) begin
        e_drv = 32'h0000_0F0F;
        e_func = b_func(m);
        if (m == 4'd10) e_logic = 32'h00AA_8977;
        else e_strobe = 1'b0;
      end
      m_clk = c; m_w = w; m_mode = m;
      chk(gated == fast, {"R7/R6 clock gate seen ", why}, {31'b0, gated}, {31'b0, fast});
      repeat (3) @(negedge clk);
      chk(busy == 1'b1, {"R11 busy while waiting ", why}, {31'b0, busy}, 32'd1);
      init_done = 1'b1;
      @(negedge clk);
      init_done = 1'b0;
      chk(busy == 1'b0, {"R11 idle after done ", why}, {31'b0, busy}, 32'd0);
    end else begin
      chk(busy == 1'b0, {"R2 no activity ", why}, {31'b0, busy}, 32'd0);
    end
    check_regs(why);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [19:0] rates [7];
    void'($urandom(32'd7321));
    rates = '{20'd400, 20'd25000, 20'd50000, 20'd52000, 20'd52001, 20'd100000, 20'd200000};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_regs("reset");
    chk(busy == 1'b0 && init_start == 1'b0, "R11 reset idle", {30'b0, busy, init_start}, 32'd0);

    apply(20'd400,    2'd0, 4'd0, 1'b0, 1'b0, "legacy no strap");
    apply(20'd400,    2'd0, 4'd0, 1'b1, 1'b1, "R2 sdio/strap only");
    apply(20'd25000,  2'd0, 4'd0, 1'b0, 1'b1, "legacy strap");
    apply(20'd0,      2'd0, 4'd0, 1'b0, 1'b1, "R1 zero clock");
    apply(20'd25000,  2'd0, 4'd0, 1'b0, 1'b1, "R1 same clock again");
    apply(20'd52000,  2'd1, 4'd4, 1'b1, 1'b0, "R4 sdr25 sdio at limit");
    apply(20'd52001,  2'd1, 4'd4, 1'b1, 1'b0, "R4 sdr25 sdio above limit");
    apply(20'd200000, 2'd2, 4'd10, 1'b0, 1'b0, "R10 hs400");
    apply(20'd50000,  2'd2, 4'd8, 1'b0, 1'b0, "R8 ddr52");
    apply(20'd200000, 2'd2, 4'd9, 1'b0, 1'b1, "R8 hs200");
    apply(20'd50000,  2'd1, 4'd1, 1'b0, 1'b1, "R4 sd-hs strap");
    apply(20'd50000,  2'd1, 4'd0, 1'b1, 1'b0, "R5 legacy keeps sdio bit");
    apply(20'd100000, 2'd2, 4'd6, 1'b1, 1'b0, "R5 sdr104 sdio");

    for (int n = 0; n < 60; n++) begin
      logic [3:0] mm;
      mm = 4'($urandom_range(0, 10));
      apply((($urandom_range(0, 9)) == 0) ? 20'd0 : rates[$urandom_range(0, 6)],
            2'($urandom_range(0, 2)), mm, 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)), "random");
    end

    done_flag = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule